// File: doc/BRIEF.md
# Numerically Controlled PWM Source

This block produces one pulse-width-modulated bit whose frequency, starting phase and high time are each set by a digital word. A wide phase accumulator advances by a frequency word on every system clock. The top nine accumulator bits, offset by a phase word, form the phase of the waveform. One more accumulator bit below them refines that phase into a 10-bit compare value. There is no waveform table. A comparator on the compare value decides whether the output is high, and the result is registered so the output cannot glitch.

Typical use is one channel of a multi-phase gate-drive generator. Several copies share a frequency word and differ only in their phase word. The duty word trims the high time below one half of the period, which leaves dead time between complementary switches of a half-bridge. A change of the frequency word takes effect on the next clock. The accumulator keeps counting through the change, so the output phase stays continuous. With a 50 MHz clock, one frequency step is about 0.745 Hz. A word of 0x0F000 gives roughly 45.8 kHz.

Top module: `nco_pwm_gen`

## Requirements
- R1: A synchronous reset clears the 26-bit accumulator to zero and drives `pwmOut` low. After release, the first clock edge evaluates the output from accumulator value 0.
- R2: On every clock edge outside reset, the accumulator adds the 17-bit `freqWord` modulo 2^26. The output period is therefore 2^26 / `freqWord` clocks. For example, 0x10000 gives 1024 clocks and 0x04000 gives 4096 clocks.
- R3: The compare value is 10 bits wide. Its upper 9 bits are (accumulator bits [25:17] + `phaseWord`) modulo 512, and its least significant bit is accumulator bit 16. Each step of `phaseWord` shifts the waveform by 360/512 degrees.
- R4: The output is high exactly when the compare value is at least `dutyWord` and below 512. Over one full period, the high fraction is (512 − `dutyWord`)/1024. A `dutyWord` of 0 gives 50%, and a `dutyWord` of 511 gives one compare step.
- R5: The output is never high while the compare value is 512 or above, so the duty cycle never exceeds 50%.
- R6: A change of `freqWord` never clears or reloads the accumulator. Counting continues from the value it held.
- R7: `pwmOut` is a register. After each edge, it shows the comparison made on the accumulator value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | 17 | Step added to the accumulator each clock |
| phaseWord | input | 9 | Phase offset in 1/512 turn steps |
| dutyWord | input | 9 | High-time trim; 0 gives 50% |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The bench goes after the following corner cases.
- **Phase wrap:** phase words that push the compare start into the upper half or past the duty threshold. A design that added the offset at the wrong bit, or did not wrap it modulo 512, would rise at the wrong clock.
- **Extreme duty words:** a duty word of 511 must give a single high clock and a duty word of 0 exactly half a period. An off-by-one comparator would give two high clocks or none, and a design missing the upper-half bound would exceed 50%.
- **Mid-run frequency change:** the frequency word is halved partway through a period. A design that restarts the accumulator on the change would move the falling edge away from clock 925.
- **Reset and latency:** a reset in the middle of a run must pull the output low on the next edge. A design without the output register, or with an extra one, would shift every first-rise time by one clock.

// File: rtl/nco_pwm_pkg.sv
package nco_pwm_pkg;

  // Default widths of the generator
  localparam int unsigned DEF_ACC_W   = 26;
  localparam int unsigned DEF_FREQ_W  = 17;
  localparam int unsigned DEF_PHASE_W = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero the accumulator
    logic advance;  // add the frequency step
    logic outLoad;  // capture the comparator result
  } ctrlStrobe_t;

endpackage

// File: rtl/nco_pwm_datapath.sv
module nco_pwm_datapath
  import nco_pwm_pkg::*;
#(
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned FREQ_W  = DEF_FREQ_W,
  parameter int unsigned PHASE_W = DEF_PHASE_W
) (
  input  logic                 clk,
  input  ctrlStrobe_t          strobes,
  input  logic [FREQ_W-1:0]    freqWord,
  input  logic [PHASE_W-1:0]   phaseWord,
  input  logic [PHASE_W-1:0]   dutyWord,
  output logic [ACC_W-1:0]     accValue,
  output logic [PHASE_W:0]     cmpPhase,
  output logic                 windowHit
);

  localparam int unsigned CMP_W   = PHASE_W + 1;
  localparam int unsigned FINE_BIT = ACC_W - PHASE_W - 1;

  logic [ACC_W-1:0]   accReg;
  logic [PHASE_W-1:0] coarsePhase;
  logic               finePhase;
  logic [CMP_W-1:0]   dutyExt;

  // Phase accumulator, never reloaded by a step change
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      accReg <= '0;
    end else if (strobes.advance) begin
      accReg <= accReg + ACC_W'(freqWord);
    end
  end

  // Coarse phase with offset (wraps naturally); fine bit appended below it
  always_comb begin
    coarsePhase = accReg[ACC_W-1 -: PHASE_W] + phaseWord;
    finePhase   = accReg[FINE_BIT];
    cmpPhase    = {coarsePhase, finePhase};
    dutyExt     = {1'b0, dutyWord};
  end

  // Comparator replaces a waveform table: lower half above the duty threshold
  always_comb begin
    windowHit = ~cmpPhase[CMP_W-1] && (cmpPhase >= dutyExt);
  end

  assign accValue = accReg;

endmodule

// File: rtl/nco_pwm_ctrl.sv
module nco_pwm_ctrl
  import nco_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        windowHit,
  output ctrlStrobe_t strobes,
  output logic        pwmOut
);

  typedef enum logic {ST_RESET, ST_RUN} runState_t;

  runState_t stateNext;
  logic      pwmReg;

  always_comb begin
    stateNext       = rst ? ST_RESET : ST_RUN;
    strobes.clear   = (stateNext == ST_RESET);
    strobes.advance = (stateNext == ST_RUN);
    strobes.outLoad = (stateNext == ST_RUN);
  end

  // Registered output keeps the pin free of comparator glitches
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      pwmReg <= 1'b0;
    end else if (strobes.outLoad) begin
      pwmReg <= windowHit;
    end
  end

  assign pwmOut = pwmReg;

endmodule

// File: rtl/nco_pwm_gen.sv
module nco_pwm_gen
  import nco_pwm_pkg::*;
#(
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned FREQ_W  = DEF_FREQ_W,
  parameter int unsigned PHASE_W = DEF_PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FREQ_W-1:0]  freqWord,
  input  logic [PHASE_W-1:0] phaseWord,
  input  logic [PHASE_W-1:0] dutyWord,
  output logic               pwmOut
);

  ctrlStrobe_t        strobes;
  logic [ACC_W-1:0]   accValue;
  logic [PHASE_W:0]   cmpPhase;
  logic               windowHit;

  nco_pwm_datapath #(
    .ACC_W  (ACC_W),
    .FREQ_W (FREQ_W),
    .PHASE_W(PHASE_W)
  ) dp (
    .clk      (clk),
    .strobes  (strobes),
    .freqWord (freqWord),
    .phaseWord(phaseWord),
    .dutyWord (dutyWord),
    .accValue (accValue),
    .cmpPhase (cmpPhase),
    .windowHit(windowHit)
  );

  nco_pwm_ctrl ctrl (
    .clk      (clk),
    .rst      (rst),
    .windowHit(windowHit),
    .strobes  (strobes),
    .pwmOut   (pwmOut)
  );

endmodule

// File: rtl/nco_pwm_checker.sv
module nco_pwm_checker #(
  parameter int unsigned ACC_W   = 26,
  parameter int unsigned FREQ_W  = 17,
  parameter int unsigned PHASE_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic [FREQ_W-1:0]  freqWord,
  input logic [PHASE_W-1:0] dutyWord,
  input logic [ACC_W-1:0]   accValue,
  input logic [PHASE_W:0]   cmpPhase,
  input logic               pwmOut
);

  // R1: reset forces the output low on the next edge
  a_r1_reset_out: assert property (@(posedge clk) rst |=> !pwmOut);

  // R1: reset zeroes the accumulator
  a_r1_reset_acc: assert property (@(posedge clk) rst |=> (accValue == '0));

  // R2 and R6: every running edge adds the step, whatever the step did
  a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (accValue == $past(accValue) + ACC_W'($past(freqWord))));

  // R5: upper half of the compare range never yields a high output
  a_r5_upper_half_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmpPhase[PHASE_W])) |-> !pwmOut);

  // R4: below the duty threshold the output is low
  a_r4_below_duty_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cmpPhase) < {1'b0, $past(dutyWord)})) |-> !pwmOut);

  // R4 and R7: inside the window the output is high one edge later
  a_r7_window_high: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cmpPhase[PHASE_W]) &&
     ($past(cmpPhase) >= {1'b0, $past(dutyWord)})) |-> pwmOut);

endmodule

bind nco_pwm_gen nco_pwm_checker #(
  .ACC_W  (ACC_W),
  .FREQ_W (FREQ_W),
  .PHASE_W(PHASE_W)
) chk (
  .clk     (clk),
  .rst     (rst),
  .freqWord(freqWord),
  .dutyWord(dutyWord),
  .accValue(accValue),
  .cmpPhase(cmpPhase),
  .pwmOut  (pwmOut)
);

// File: tb/nco_pwm_gen_test.sv
module nco_pwm_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] freqWord = '0;
  logic [8:0]  phaseWord = '0;
  logic [8:0]  dutyWord = '0;
  logic        pwmOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  nco_pwm_gen uut (
    .clk      (clk),
    .rst      (rst),
    .freqWord (freqWord),
    .phaseWord(phaseWord),
    .dutyWord (dutyWord),
    .pwmOut   (pwmOut)
  );

  typedef struct packed {
    logic [16:0] f;
    logic [8:0]  p;
    logic [8:0]  d;
    logic [15:0] window;
    logic [15:0] count;
    logic [15:0] first;
  } vec_t;

  // Expected counts follow R2/R4; first-rise clock follows R3/R7
  localparam vec_t VECS [9] = '{
    '{17'h10000, 9'd0,   9'd0,   16'd1024, 16'd512,  16'd1},
    '{17'h10000, 9'd0,   9'd100, 16'd1024, 16'd412,  16'd101},
    '{17'h10000, 9'd128, 9'd0,   16'd1024, 16'd512,  16'd1},
    '{17'h10000, 9'd256, 9'd0,   16'd1024, 16'd512,  16'd513},
    '{17'h10000, 9'd384, 9'd50,  16'd1024, 16'd462,  16'd307},
    '{17'h10000, 9'd10,  9'd200, 16'd1024, 16'd312,  16'd181},
    '{17'h10000, 9'd0,   9'd511, 16'd1024, 16'd1,    16'd512},
    '{17'h04000, 9'd0,   9'd0,   16'd4096, 16'd2048, 16'd1},
    '{17'h04000, 9'd0,   9'd256, 16'd4096, 16'd1024, 16'd1025}
  };

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // Edge k is the k-th posedge after reset release; sample at the next negedge
  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [16:0] f, input logic [8:0] p, input logic [8:0] d);
    @(negedge clk);
    rst = 1'b1;
    freqWord = f;
    phaseWord = p;
    dutyWord = d;
    stepEdge();
    stepEdge();
    rst = 1'b0;
  endtask

  initial begin
    int highCount;
    int firstHigh;

    // R1: reset state
    doReset(17'h10000, 9'd0, 9'd0);
    @(negedge clk);
    rst = 1'b1;
    stepEdge();
    check("R1 reset output", int'(pwmOut), 0);
    rst = 1'b0;

    // Vector table
    for (int v = 0; v < 9; v++) begin
      doReset(VECS[v].f, VECS[v].p, VECS[v].d);
      highCount = 0;
      firstHigh = 0;
      for (int k = 1; k <= int'(VECS[v].window); k++) begin
        stepEdge();
        if (pwmOut) begin
          highCount++;
          if (firstHigh == 0) firstHigh = k;
        end
      end
      check($sformatf("R2 R4 high count vec%0d", v), highCount, int'(VECS[v].count));
      check($sformatf("R3 R7 first rise vec%0d", v), firstHigh, int'(VECS[v].first));
    end

    // R5: zero duty is high for exactly the lower half
    doReset(17'h10000, 9'd0, 9'd0);
    for (int k = 1; k <= 513; k++) begin
      stepEdge();
      if (k == 512) check("R5 last high clock", int'(pwmOut), 1);
      if (k == 513) check("R5 upper half low", int'(pwmOut), 0);
    end

    // R6: halve the step after edge 100; fall expected at edge 925
    doReset(17'h10000, 9'd0, 9'd0);
    for (int k = 1; k <= 100; k++) stepEdge();
    freqWord = 17'h08000;
    for (int k = 101; k <= 925; k++) begin
      stepEdge();
      if (k == 924) check("R6 still high before fall", int'(pwmOut), 1);
      if (k == 925) check("R6 continuous fall", int'(pwmOut), 0);
    end

    // R1: reset in mid-run while the output is high
    doReset(17'h10000, 9'd0, 9'd0);
    for (int k = 1; k <= 10; k++) stepEdge();
    check("R1 high before mid-run reset", int'(pwmOut), 1);
    rst = 1'b1;
    stepEdge();
    check("R1 mid-run reset low", int'(pwmOut), 0);
    rst = 1'b0;
    dutyWord = 9'd3;
    firstHigh = 0;
    for (int k = 1; k <= 8; k++) begin
      stepEdge();
      if (pwmOut && firstHigh == 0) firstHigh = k;
    end
    check("R1 restart from zero", firstHigh, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule